// File: doc/BRIEF.md
# DMA Channel Interrupt and Run-Control Fabric

This block is the interrupt and run-control fabric of a multi-channel DMA engine in which each channel has a fixed direction. Even channels move data from memory to a device (transmit). Odd channels move data from a device to memory (receive). The channel datapaths are outside the block. They show up here only as one-cycle event pulses: a descriptor-done event and an error event per channel.

For each channel, the block keeps a status register and a mask register for every interrupt output. An event sets the matching status bit in every output's copy. Software clears a status bit by writing 1 to it. For each output, the enabled causes are combined into a transmit summary word and a receive summary word. Both words index channels by channel number divided by two. A level interrupt is raised while any summary bit of that output is set. Four write-only command words set or clear the per-channel run bits of one direction. Two read-only words report those run bits.

Software reaches all of this over a plain address/data bus. A write is a single cycle with `bus_we` high. Read data is a combinational function of `bus_addr`.

Top module: `dmairq_fabric`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every status bit, every mask bit, every run bit, `run_o` and `irq_o`.
- R2: A pulse on `evt_done[c]` sets status bit 0 of channel c, and a pulse on `evt_err[c]` sets status bit 6, in the status register of every output, whatever the mask holds. The status register of channel c, output o, is at word address 0x100 + 8·c + o.
- R3: Writing a status register clears each bit written as 1. Bits written as 0 keep their value. If an event for a bit arrives in the same cycle as a write-1 clear of that bit, the bit stays set.
- R4: The mask register of channel c, output o, is at word address 0x100 + 8·c + 4 + o and can be read and written. Only bits 0 and 6 are stored, and every other bit reads 0.
- R5: The transmit summary of output o is at word 0x010 + o, and the receive summary is at word 0x018 + o. Bit c/2 of the word matching channel c's direction is high when (status AND mask) of channel c for output o is non-zero.
- R6: `irq_o[o]` is high exactly when any bit of output o's transmit or receive summary is high.
- R7: Writing word 0x000 (transmit start) or word 0x002 (receive start) sets, from the next cycle on, the run bit of channel 2k or 2k+1 respectively for each data bit k written as 1. Bits written as 0 have no effect.
- R8: Writing word 0x001 (transmit stop) or word 0x003 (receive stop) clears, from the next cycle on, the run bit of each channel whose bit c/2 is written as 1. Words 0x004 and 0x005 read back the transmit and receive run bits at bit c/2, and `run_o[c]` shows the run bit of channel c.
- R9: Reads of the command words, of unmapped addresses, and of channel or output numbers beyond the configured counts return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| evt_done | input | NUM_CH | Descriptor-done event pulse, one bit per channel |
| evt_err | input | NUM_CH | Error event pulse, one bit per channel |
| run_o | output | NUM_CH | Run bit of each channel |
| irq_o | output | NUM_OUT | Level interrupt, one bit per output |

## Verification
Two functions can act on the same status bit in the same cycle: the event from the datapath that sets it, and the software write-1 that clears it. The bench provokes this by holding `evt_err` high during the very clock edge that carries a clearing write to the same register. It then judges by reading the register back: the bit must still be set. A clear with no event present must then bring both the bit and the interrupt down. Direction steering is judged by giving a transmit channel and a receive channel enabled causes on different outputs, and checking which summary word and which bit position light up.

// File: rtl/dmairq_pkg.sv
// Package: shared address map and field positions of the interrupt fabric.
// Assumes word addressing and at most four outputs per channel.
package dmairq_pkg;
    localparam int DONE_BIT = 0;
    localparam int ERR_BIT  = 6;

    localparam int A_TX_START = 'h000;
    localparam int A_TX_STOP  = 'h001;
    localparam int A_RX_START = 'h002;
    localparam int A_RX_STOP  = 'h003;
    localparam int A_TX_RUN   = 'h004;
    localparam int A_RX_RUN   = 'h005;
    localparam int A_TX_SUM   = 'h010;
    localparam int A_RX_SUM   = 'h018;
    localparam int A_CH_BASE  = 'h100;
    localparam int CH_STRIDE  = 8;

    typedef enum logic [2:0] {
        DEC_NONE,
        DEC_CMD,
        DEC_RUN,
        DEC_SUM,
        DEC_STAT,
        DEC_MASK
    } dec_kind_e;
endpackage

// File: rtl/dmairq_addr_dec.sv
// Address decoder: sorts a word address into a region, a channel and an output.
// Assumes NUM_OUT <= 4 and that channel windows are CH_STRIDE words apart.
module dmairq_addr_dec
    import dmairq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_CH  = 8,
    parameter int NUM_OUT = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int OUT_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_kind_e         kind,
    output logic              is_rx,
    output logic              is_stop,
    output logic [CH_W-1:0]   ch,
    output logic [OUT_W-1:0]  out_idx
);
    logic [ADDR_W-1:0] off;
    int unsigned       ch_num;

    // Purpose: classify the address and extract the channel and output indices.
    always_comb begin
        off     = addr - ADDR_W'(A_CH_BASE);
        ch_num  = int'(off) / CH_STRIDE;
        kind    = DEC_NONE;
        is_rx   = 1'b0;
        is_stop = 1'b0;
        ch      = '0;
        out_idx = addr[OUT_W-1:0];
        if (int'(addr) <= A_RX_STOP) begin
            kind    = DEC_CMD;
            is_rx   = addr[1];
            is_stop = addr[0];
        end else if (int'(addr) == A_TX_RUN || int'(addr) == A_RX_RUN) begin
            kind  = DEC_RUN;
            is_rx = addr[0];
        end else if (int'(addr) >= A_TX_SUM && int'(addr) < A_TX_SUM + NUM_OUT) begin
            kind = DEC_SUM;
        end else if (int'(addr) >= A_RX_SUM && int'(addr) < A_RX_SUM + NUM_OUT) begin
            kind  = DEC_SUM;
            is_rx = 1'b1;
        end else if (int'(addr) >= A_CH_BASE && ch_num < NUM_CH
                     && int'(addr[1:0]) < NUM_OUT) begin
            ch   = CH_W'(ch_num);
            kind = addr[2] ? DEC_MASK : DEC_STAT;
        end
    end
endmodule

// File: rtl/dmairq_chan_regs.sv
// Channel register set: one status and one mask register per interrupt output.
// An event sets its status bit in every output's copy. A write-1 clears a bit,
// and a simultaneous event wins. The pending flag is the OR of (status AND mask).
module dmairq_chan_regs #(
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_done,
    input  logic               evt_err,
    input  logic [NUM_OUT-1:0] st_wr,
    input  logic [NUM_OUT-1:0] mk_wr,
    input  logic               wdone,
    input  logic               werr,
    output logic [NUM_OUT-1:0] st_done,
    output logic [NUM_OUT-1:0] st_err,
    output logic [NUM_OUT-1:0] mk_done,
    output logic [NUM_OUT-1:0] mk_err,
    output logic [NUM_OUT-1:0] pend
);
    // Purpose: status bits, set by events and cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= '0;
            st_err  <= '0;
        end else begin
            st_done <= (st_done & ~(st_wr & {NUM_OUT{wdone}})) | {NUM_OUT{evt_done}};
            st_err  <= (st_err  & ~(st_wr & {NUM_OUT{werr}}))  | {NUM_OUT{evt_err}};
        end
    end

    // Purpose: mask bits, loaded by plain writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mk_done <= '0;
            mk_err  <= '0;
        end else begin
            for (int o = 0; o < NUM_OUT; o++) begin
                if (mk_wr[o]) begin
                    mk_done[o] <= wdone;
                    mk_err[o]  <= werr;
                end
            end
        end
    end

    // Purpose: enabled causes of each output.
    always_comb pend = (st_done & mk_done) | (st_err & mk_err);

    AST_EVT_SETS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> (&st_done)) else $error("done event lost"); // R2
    AST_ERR_SETS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |=> (&st_err)) else $error("error event lost"); // R2
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_done && !evt_err && st_wr == '0) |=> ($stable(st_done) && $stable(st_err)))
        else $error("status changed without cause"); // R3

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (st_wr[o] && werr && !evt_err) |=> !st_err[o])
            else $error("write-1 clear ignored"); // R3
    end
endmodule

// File: rtl/dmairq_run_ctrl.sv
// Run control: per-channel run bits driven by the direction start/stop words.
// Bit k of a transmit word acts on channel 2k and bit k of a receive word on
// channel 2k+1. Stop takes priority over start. Assumes NUM_CH is even.
module dmairq_run_ctrl #(
    parameter int NUM_CH = 8,
    localparam int HALF  = NUM_CH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic              tx_stop,
    input  logic              rx_start,
    input  logic              rx_stop,
    input  logic [HALF-1:0]   bits,
    output logic [NUM_CH-1:0] run_q
);
    for (genvar k = 0; k < HALF; k++) begin : g_pair
        // Purpose: run bit of the transmit channel 2k.
        always_ff @(posedge clk) begin
            if (!rst_n)                   run_q[2*k] <= 1'b0;
            else if (tx_stop && bits[k])  run_q[2*k] <= 1'b0;
            else if (tx_start && bits[k]) run_q[2*k] <= 1'b1;
        end

        // Purpose: run bit of the receive channel 2k+1.
        always_ff @(posedge clk) begin
            if (!rst_n)                   run_q[2*k+1] <= 1'b0;
            else if (rx_stop && bits[k])  run_q[2*k+1] <= 1'b0;
            else if (rx_start && bits[k]) run_q[2*k+1] <= 1'b1;
        end

        AST_TX_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_start && !tx_stop && bits[k]) |=> run_q[2*k]) else $error("tx start lost"); // R7
        AST_RX_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_stop && bits[k]) |=> !run_q[2*k+1]) else $error("rx stop lost"); // R8
        AST_RUN_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!tx_start && !tx_stop && !rx_start && !rx_stop) |=> $stable(run_q[2*k+1:2*k]))
            else $error("run bit moved without a command"); // R7
    end
endmodule

// File: rtl/dmairq_fabric.sv
// Top: ties together the decoder, the per-channel register sets, the run
// control, the per-direction summaries, the interrupt lines and the read mux.
// Assumes NUM_CH is even, NUM_CH <= 2*DATA_W, NUM_OUT <= 4, DATA_W >= 7.
module dmairq_fabric
    import dmairq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_CH  = 8,
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0]  evt_done,
    input  logic [NUM_CH-1:0]  evt_err,
    output logic [NUM_CH-1:0]  run_o,
    output logic [NUM_OUT-1:0] irq_o
);
    localparam int HALF  = NUM_CH / 2;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int OUT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

    dec_kind_e         d_kind;
    logic              d_rx;
    logic              d_stop;
    logic [CH_W-1:0]   d_ch;
    logic [OUT_W-1:0]  d_out;

    logic [NUM_OUT-1:0] st_done [NUM_CH];
    logic [NUM_OUT-1:0] st_err  [NUM_CH];
    logic [NUM_OUT-1:0] mk_done [NUM_CH];
    logic [NUM_OUT-1:0] mk_err  [NUM_CH];
    logic [NUM_OUT-1:0] pend    [NUM_CH];
    logic [HALF-1:0]    tx_sum  [NUM_OUT];
    logic [HALF-1:0]    rx_sum  [NUM_OUT];
    logic [HALF-1:0]    tx_run;
    logic [HALF-1:0]    rx_run;
    logic               cmd_wr;

    dmairq_addr_dec #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .NUM_OUT(NUM_OUT)
    ) u_dec (
        .addr   (bus_addr),
        .kind   (d_kind),
        .is_rx  (d_rx),
        .is_stop(d_stop),
        .ch     (d_ch),
        .out_idx(d_out)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_OUT-1:0] st_wr;
        logic [NUM_OUT-1:0] mk_wr;

        // Purpose: write strobes aimed at this channel's registers.
        always_comb begin
            for (int o = 0; o < NUM_OUT; o++) begin
                st_wr[o] = bus_we && d_kind == DEC_STAT && int'(d_ch) == c && int'(d_out) == o;
                mk_wr[o] = bus_we && d_kind == DEC_MASK && int'(d_ch) == c && int'(d_out) == o;
            end
        end

        dmairq_chan_regs #(
            .NUM_OUT(NUM_OUT)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_done(evt_done[c]),
            .evt_err (evt_err[c]),
            .st_wr   (st_wr),
            .mk_wr   (mk_wr),
            .wdone   (bus_wdata[DONE_BIT]),
            .werr    (bus_wdata[ERR_BIT]),
            .st_done (st_done[c]),
            .st_err  (st_err[c]),
            .mk_done (mk_done[c]),
            .mk_err  (mk_err[c]),
            .pend    (pend[c])
        );
    end

    assign cmd_wr = bus_we && d_kind == DEC_CMD;

    dmairq_run_ctrl #(
        .NUM_CH(NUM_CH)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_start(cmd_wr && !d_rx && !d_stop),
        .tx_stop (cmd_wr && !d_rx &&  d_stop),
        .rx_start(cmd_wr &&  d_rx && !d_stop),
        .rx_stop (cmd_wr &&  d_rx &&  d_stop),
        .bits    (bus_wdata[HALF-1:0]),
        .run_q   (run_o)
    );

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        for (genvar k = 0; k < HALF; k++) begin : g_bit
            assign tx_sum[o][k] = pend[2*k][o];
            assign rx_sum[o][k] = pend[2*k+1][o];
        end
        assign irq_o[o] = (|tx_sum[o]) | (|rx_sum[o]);

        AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[o] |-> $past(rst_n)) else $error("interrupt right after reset"); // R1
    end

    for (genvar k = 0; k < HALF; k++) begin : g_runpack
        assign tx_run[k] = run_o[2*k];
        assign rx_run[k] = run_o[2*k+1];
    end

    // Purpose: read data multiplexer over all readable words.
    always_comb begin
        bus_rdata = '0;
        case (d_kind)
            DEC_RUN:  bus_rdata[HALF-1:0] = d_rx ? rx_run : tx_run;
            DEC_SUM:  bus_rdata[HALF-1:0] = d_rx ? rx_sum[d_out] : tx_sum[d_out];
            DEC_STAT: begin
                bus_rdata[DONE_BIT] = st_done[d_ch][d_out];
                bus_rdata[ERR_BIT]  = st_err[d_ch][d_out];
            end
            DEC_MASK: begin
                bus_rdata[DONE_BIT] = mk_done[d_ch][d_out];
                bus_rdata[ERR_BIT]  = mk_err[d_ch][d_out];
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/dmairq_fabric_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module dmairq_fabric_bench;
    localparam int NCH = 8;
    localparam int NOUT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0]  evt_done = '0;
    logic [NCH-1:0]  evt_err = '0;
    logic [NCH-1:0]  run_o;
    logic [NOUT-1:0] irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dmairq_fabric #(.NUM_CH(NCH), .NUM_OUT(NOUT)) u_dmairq_fabric (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_done(evt_done),
        .evt_err(evt_err), .run_o(run_o), .irq_o(irq_o)
    );

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, expected fewer than 20000", cycles);
            summary();
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(logic [NCH-1:0] dn, logic [NCH-1:0] er);
        @(negedge clk);
        evt_done = dn; evt_err = er;
        @(posedge clk);
        @(negedge clk);
        evt_done = '0; evt_err = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h100, d); chk("R1 status after reset", d, 0);
        rd(12'h104, d); chk("R1 mask after reset", d, 0);
        chk("R1 run_o after reset", 32'(run_o), 0);
        chk("R1 irq_o after reset", 32'(irq_o), 0);
    endtask

    task automatic t_event_sets();
        logic [31:0] d;
        pulse(8'h08, 8'h00);
        rd(12'h118, d); chk("R2 done on ch3 out0", d, 32'h1);
        rd(12'h11A, d); chk("R2 done on ch3 out2", d, 32'h1);
        chk("R2 masked events raise no irq", 32'(irq_o), 0);
        pulse(8'h00, 8'h08);
        rd(12'h118, d); chk("R2 error bit 6 on ch3", d, 32'h41);
    endtask

    task automatic t_mask_rx();
        logic [31:0] d;
        wr(12'h11D, 32'hFFFF_FFFF);
        rd(12'h11D, d); chk("R4 mask keeps bits 0 and 6 only", d, 32'h41);
        rd(12'h019, d); chk("R5 rx summary out1 bit ch3/2", d, 32'h2);
        rd(12'h011, d); chk("R5 tx summary out1 empty", d, 0);
        chk("R6 irq on out1", 32'(irq_o), 32'h2);
    endtask

    task automatic t_tx_summary();
        logic [31:0] d;
        pulse(8'h00, 8'h10);
        wr(12'h127, 32'h40);
        rd(12'h013, d); chk("R5 tx summary out3 bit ch4/2", d, 32'h4);
        chk("R6 irq on out1 and out3", 32'(irq_o), 32'hA);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(12'h119, 32'h1);
        rd(12'h119, d); chk("R3 write-1 clears done only", d, 32'h40);
        wr(12'h119, 32'h0);
        rd(12'h119, d); chk("R3 write-0 keeps bits", d, 32'h40);
        rd(12'h118, d); chk("R3 other output copy untouched", d, 32'h41);
    endtask

    task automatic t_conflict();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = 12'h119; bus_wdata = 32'h40; bus_we = 1'b1; evt_err = 8'h08;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; evt_err = '0;
        rd(12'h119, d); chk("R3 event beats same-cycle clear", d, 32'h40);
        chk("R6 irq still on out1", 32'(irq_o), 32'hA);
        wr(12'h119, 32'h40);
        rd(12'h119, d); chk("R3 clear without event", d, 0);
        chk("R6 irq out1 drops", 32'(irq_o), 32'h8);
    endtask

    task automatic t_run();
        logic [31:0] d;
        wr(12'h000, 32'h5);
        chk("R7 tx start ch0 and ch4", 32'(run_o), 32'h11);
        wr(12'h002, 32'h2);
        chk("R7 rx start ch3", 32'(run_o), 32'h19);
        wr(12'h000, 32'h0);
        chk("R7 zero start bits no effect", 32'(run_o), 32'h19);
        wr(12'h001, 32'h1);
        chk("R8 tx stop ch0", 32'(run_o), 32'h18);
        rd(12'h004, d); chk("R8 tx run word", d, 32'h4);
        rd(12'h005, d); chk("R8 rx run word", d, 32'h2);
        wr(12'h003, 32'h2);
        chk("R8 rx stop ch3", 32'(run_o), 32'h10);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'h000, d); chk("R9 command word reads zero", d, 0);
        rd(12'h0FF, d); chk("R9 hole reads zero", d, 0);
        rd(12'h014, d); chk("R9 summary of absent output", d, 0);
        rd(12'h140, d); chk("R9 absent channel reads zero", d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_event_sets();
        t_mask_rx();
        t_tx_summary();
        t_w1c();
        t_conflict();
        t_run();
        t_unmapped();
        summary();
    end
endmodule